// File: doc/BRIEF.md
# Receive Byte Queue with Threshold Interrupt

This block buffers bytes arriving from a serial receiver until a host collects them. The receiver presents a byte together with a one-cycle write strobe. The host pops the oldest byte with a read strobe. The oldest byte is always visible on the read data port whenever the queue holds anything. An occupancy count is kept and is shown to the host at all times.

The host programs a fill threshold. Once the number of stored bytes reaches that threshold, a ready flag is raised. If the host has enabled the interrupt, an interrupt request is raised as well. This lets the host service the receiver in bursts rather than once per byte.

A byte that arrives while the queue is already full is discarded. The stored bytes are left untouched, and an overrun pulse reports the loss. Capacity and byte width are parameters, with defaults of 64 entries of 8 bits. A parameter can also register the flags for timing, which adds one cycle of latency.

Top module: `rx_thresh_fifo`

## Requirements
- R1: After reset `level` is 0 and `ready`, `irq` and `overrun` are 0.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest stored byte whenever `level` is non-zero.
- R3: A write on its own raises `level` by one. A read on its own lowers it by one. The new value is visible after the clock edge that takes the strobe.
- R4: Capacity is 64 bytes by default. A write while `level` equals the capacity and no read is made is discarded, and the stored bytes are kept. `overrun` is high for exactly the one cycle after each discarded write.
- R5: With the default unregistered flags, `ready` is 1 exactly when `level` is greater than or equal to the threshold. It therefore clears as soon as reads bring `level` below the threshold.
- R6: A threshold of 0 acts as a threshold of 1.
- R7: `irq` equals `ready` AND `irq_en`. With `irq_en` low, `irq` stays 0 even while `ready` is 1.
- R8: A write and a read in the same cycle with `level` non-zero leave `level` unchanged. The oldest byte is removed and the new byte is appended.
- R9: A read while `level` is 0 is ignored, so `level` stays 0. A simultaneous write is still accepted.
- R10: A write and a read in the same cycle while full are both taken, and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte-arrival strobe from the receiver |
| wr_data | input | 8 | Arriving byte |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Oldest stored byte |
| thr | input | 7 | Fill threshold (0 acts as 1) |
| irq_en | input | 1 | Interrupt enable |
| ready | output | 1 | Level has reached the threshold |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | One-cycle pulse after a discarded byte |
| level | output | 7 | Number of stored bytes |

## Verification
The fill-and-drain pattern uses a threshold of 4. It separates a flag that fires on the first byte from one that follows the count in both directions. Filling to capacity with distinct byte values and then pushing one more byte shows whether the extra byte overwrote data, moved a pointer, or was dropped cleanly with a single overrun pulse. Simultaneous strobes are tried at three levels: empty, partly filled and full. These reveal a counter that treats the paired strobes wrongly at the boundaries. Threshold zero and a masked enable check the flag decode apart from the storage.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   // Effective threshold: zero is promoted to one.
   function automatic int unsigned rxf_eff_thr(input int unsigned t);
      return (t == 0) ? 1 : t;
   endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr_q, rptr_q;

   always_ff @(posedge clk) begin
      if (push) mem[wptr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (push) wptr_q <= wptr_q + AW'(1);
         if (pop)  rptr_q <= rptr_q + AW'(1);
      end
   end

   assign dout = mem[rptr_q];
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic          rd_i,
   output logic          push_o,
   output logic          pop_o,
   output logic [CW-1:0] count_o,
   output logic          ovr_o
);
   logic [CW-1:0] count_q;
   logic          ovr_q;
   logic          drop;

   assign pop_o  = rd_i && (count_q != '0);
   assign push_o = wr_i && ((count_q != CW'(DEPTH)) || pop_o);
   assign drop   = wr_i && !push_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         ovr_q   <= 1'b0;
      end else begin
         ovr_q <= drop;
         case ({push_o, pop_o})
            2'b10:   count_q <= count_q + CW'(1);
            2'b01:   count_q <= count_q - CW'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   assign count_o = count_q;
   assign ovr_o   = ovr_q;

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));
   assert_ovr_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !rd_i && count_q == CW'(DEPTH)) |=> (ovr_q && count_q == CW'(DEPTH)));
   assert_simul_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && rd_i && count_q != '0) |=> $stable(count_q));
   assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !wr_i && count_q == '0) |=> (count_q == '0));
   assert_full_simul_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && rd_i && count_q == CW'(DEPTH)) |=> !ovr_q);
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
   import rxf_pkg::*;
#(
   parameter int DEPTH    = 64,
   parameter bit FLAG_REG = 1'b0,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count_i,
   input  logic [CW-1:0] thr_i,
   input  logic          irq_en_i,
   output logic          ready_o,
   output logic          irq_o
);
   logic ready_raw;

   assign ready_raw = int'(count_i) >= int'(rxf_eff_thr(int'(thr_i)));

   generate
      if (FLAG_REG) begin : g_reg
         logic ready_q, irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ready_q <= 1'b0;
               irq_q   <= 1'b0;
            end else begin
               ready_q <= ready_raw;
               irq_q   <= ready_raw && irq_en_i;
            end
         end
         assign ready_o = ready_q;
         assign irq_o   = irq_q;
      end else begin : g_comb
         assign ready_o = ready_raw;
         assign irq_o   = ready_raw && irq_en_i;
         assert_ready_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ready_o |-> (count_i != '0));
      end
   endgenerate
endmodule

// File: rtl/rx_thresh_fifo.sv
module rx_thresh_fifo #(
   parameter int WIDTH    = 8,
   parameter int DEPTH    = 64,
   parameter bit FLAG_REG = 1'b0,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   input  logic [CW-1:0]    thr,
   input  logic             irq_en,
   output logic             ready,
   output logic             irq,
   output logic             overrun,
   output logic [CW-1:0]    level
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rx_thresh_fifo: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("rx_thresh_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic push, pop;

   rxf_level #(.DEPTH(DEPTH)) u_level (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .rd_i(rd_en),
      .push_o(push), .pop_o(pop), .count_o(level), .ovr_o(overrun)
   );

   rxf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .din(wr_data), .dout(rd_data)
   );

   rxf_flags #(.DEPTH(DEPTH), .FLAG_REG(FLAG_REG)) u_flags (
      .clk(clk), .rst_n(rst_n), .count_i(level), .thr_i(thr),
      .irq_en_i(irq_en), .ready_o(ready), .irq_o(irq)
   );

   assert_irq_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ready);
   assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (level != '0));
endmodule

// File: tb/rx_thresh_fifo_bench.sv
module rx_thresh_fifo_bench;
   localparam int W = 8;
   localparam int D = 64;
   localparam int CW = $clog2(D + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, irq_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [CW-1:0] thr = '0;
   logic [W-1:0] rd_data;
   logic ready, irq, overrun;
   logic [CW-1:0] level;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   rx_thresh_fifo u_rx_thresh_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .thr(thr), .irq_en(irq_en),
      .ready(ready), .irq(irq), .overrun(overrun), .level(level)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One clock cycle with the given strobes; returns at the following negedge.
   task automatic cyc(input logic w, input logic [W-1:0] d, input logic r);
      @(negedge clk);
      wr_en = w; wr_data = d; rd_en = r;
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 level", int'(level), 0);
      chk("R1 ready", int'(ready), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 overrun", int'(overrun), 0);
   endtask

   task automatic t_threshold();
      do_reset();
      thr = 7'd4; irq_en = 1'b1;
      for (int i = 0; i < 3; i++) begin
         cyc(1'b1, W'(8'h10 + i), 1'b0);
         chk("R3 level rise", int'(level), i + 1);
         chk("R5 ready below", int'(ready), 0);
      end
      cyc(1'b1, 8'h13, 1'b0);
      chk("R5 ready at thr", int'(ready), 1);
      chk("R7 irq enabled", int'(irq), 1);
      for (int i = 0; i < 4; i++) begin
         chk("R2 order", int'(rd_data), 8'h10 + i);
         cyc(1'b0, 8'h00, 1'b1);
         chk("R3 level fall", int'(level), 3 - i);
         chk("R5 ready clears", int'(ready), 0);
      end
   endtask

   task automatic t_thr_zero_mask();
      do_reset();
      thr = 7'd0; irq_en = 1'b0;
      chk("R6 empty not ready", int'(ready), 0);
      cyc(1'b1, 8'h5A, 1'b0);
      chk("R6 zero acts as one", int'(ready), 1);
      chk("R7 irq masked", int'(irq), 0);
      irq_en = 1'b1;
      #1;
      chk("R7 irq unmasked", int'(irq), 1);
   endtask

   task automatic t_full();
      do_reset();
      thr = 7'd64; irq_en = 1'b1;
      for (int i = 0; i < D; i++) cyc(1'b1, W'(i * 3 + 1), 1'b0);
      chk("R4 full level", int'(level), D);
      chk("R4 no overrun yet", int'(overrun), 0);
      chk("R5 ready at capacity", int'(ready), 1);
      cyc(1'b1, 8'hEE, 1'b0);
      chk("R4 level kept", int'(level), D);
      chk("R4 overrun pulse", int'(overrun), 1);
      cyc(1'b0, 8'h00, 1'b0);
      chk("R4 overrun one cycle", int'(overrun), 0);
      cyc(1'b1, 8'hAB, 1'b1);
      chk("R10 full simul level", int'(level), D);
      chk("R10 no overrun", int'(overrun), 0);
      for (int i = 1; i < D; i++) begin
         if (rd_data != W'(i * 3 + 1)) chk("R4 contents kept", int'(rd_data), (i * 3 + 1) & 8'hFF);
         cyc(1'b0, 8'h00, 1'b1);
      end
      chk("R10 appended byte", int'(rd_data), 8'hAB);
      chk("R4 drained minus one", int'(level), 1);
   endtask

   task automatic t_simul();
      do_reset();
      thr = 7'd2;
      cyc(1'b0, 8'h00, 1'b1);
      chk("R9 empty read", int'(level), 0);
      cyc(1'b1, 8'hC1, 1'b1);
      chk("R9 write taken when empty", int'(level), 1);
      cyc(1'b1, 8'hC2, 1'b0);
      cyc(1'b1, 8'hC3, 1'b1);
      chk("R8 level unchanged", int'(level), 2);
      chk("R8 oldest removed", int'(rd_data), 8'hC2);
      cyc(1'b0, 8'h00, 1'b1);
      chk("R8 new byte appended", int'(rd_data), 8'hC3);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_threshold();
            t_thr_zero_mask();
            t_full();
            t_simul();
         end
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule